// File: doc/BRIEF.md
# Fractional Duty to Coarse and Fine Edge Mapper

This block turns a per-unit duty-cycle command into the two numbers a high-resolution PWM edge needs. One is a coarse compare count in timebase clocks. The other is a fine code that tells a sub-clock delay line how many extra fine steps to add. Control software can then keep every duty value as a fraction. The mapper rescales that fraction into absolute compare values for whatever PWM period and fine-step size are in use.

The scaling is done in two stages. First the duty fraction is multiplied by the period in coarse counts. The integer part of that product is the coarse compare value. Next, the fractional remainder is multiplied by the number of fine steps that fit in one coarse clock. Half a fine step is added, and the sum is truncated. The fine code is kept within 1 to 255. A flag reports any case where the result had to be forced into range, including a duty command above 1.0.

The block accepts one command per clock and is always ready. Its results appear a fixed three clocks later, with a one-cycle valid pulse.

Top module: `duty_edge_mapper`

## Requirements
- R1: `out_coarse` equals floor(D × P / 32768). Here D is `in_duty`, read as unsigned Q15 (0x8000 is exactly 1.0), and P is `in_period`.
- R2: The unclamped fine code equals (F × S + 16384) >> 15. Here F is the low 15 bits of D × P and S is `in_scale`. A remainder of exactly half a fine step rounds up, and anything below half rounds down.
- R3: The fine code on the output is never below 1 or above 255. A value outside that range is replaced by the nearest limit, and `out_clamp` is set with that result.
- R4: A duty above 0x8000 is treated as exactly 0x8000. The result is then coarse = P and fine = 1, and `out_clamp` is set.
- R5: `out_fine` carries the fine code in bits [15:8], and bits [7:0] are always zero.
- R6: Inputs are captured at a rising edge while `in_valid` is high. `out_valid` goes high for one cycle after the third rising edge, counting the capturing edge as the first. `in_ready` is always 1, so a new command can be accepted on every edge.
- R7: While `in_valid` is low, the inputs are ignored. While `out_valid` is low, `out_coarse`, `out_fine` and `out_clamp` keep their last values.
- R8: While `rst_n` is low, `out_valid`, `out_coarse`, `out_fine` and `out_clamp` are all 0. Commands still in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 1 | A command is present on the input lines |
| in_ready | output | 1 | Always 1 |
| in_duty | input | 16 | Duty fraction, unsigned Q15 |
| in_period | input | 16 | PWM period in coarse counts |
| in_scale | input | 8 | Fine steps per coarse count |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_coarse | output | 16 | Coarse compare count |
| out_fine | output | 16 | Fine code in the upper byte; the lower byte is zero |
| out_clamp | output | 1 | The result was forced into range |

## Verification
The bench builds the mapper with its default parameters: a Q15 duty, a 16-bit period and an 8-bit scale. With these widths, a single table can reach several key cases. These are the 30% example, whose result is coarse 21 and fine 37. They also include a period of 65535 with duty 0x7FFF, where the fine result falls to zero and is clamped. Other vectors hit the exact half-step round-up, a scale of zero, and duties of 0, 1.0 and above 1.0. With an 8-bit scale the upper clamp cannot be reached, because the unclamped code never exceeds the scale. That path is therefore guarded only by an assertion. The table is sent back to back to exercise full throughput. Directed tests then check a lone pulse, inputs that change while idle, and a reset taken while commands are in flight.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  // control carried beside each pipeline stage
  typedef struct packed {
    logic vld;
    logic flag;
  } stage_ctl_t;
endpackage

// File: rtl/mapper_scale_stage.sv
module mapper_scale_stage
  import mapper_pkg::*;
#(
  parameter int DUTY_FRAC = 15,
  parameter int PER_W     = 16,
  parameter int SCL_W     = 8,
  localparam int DUTY_W   = DUTY_FRAC + 1,
  localparam int PROD_W   = DUTY_W + PER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DUTY_W-1:0] in_duty,
  input  logic [PER_W-1:0]  in_period,
  input  logic [SCL_W-1:0]  in_scale,
  output stage_ctl_t        s1_ctl,
  output logic [PROD_W-1:0] s1_prod,
  output logic [SCL_W-1:0]  s1_scale
);
  localparam logic [DUTY_W-1:0] UNITY = DUTY_W'(1) << DUTY_FRAC;

  logic              over_d;
  logic [DUTY_W-1:0] duty_eff;
  logic [PROD_W-1:0] prod_d;

  always_comb begin
    over_d   = in_duty > UNITY;
    duty_eff = over_d ? UNITY : in_duty;
    prod_d   = PROD_W'(duty_eff) * PROD_W'(in_period);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ctl   <= '0;
      s1_prod  <= '0;
      s1_scale <= '0;
    end else begin
      s1_ctl.vld <= in_valid;
      if (in_valid) begin
        s1_ctl.flag <= over_d;
        s1_prod     <= prod_d;
        s1_scale    <= in_scale;
      end
    end
  end

  // R1
  prod_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (s1_prod >> DUTY_FRAC) <= PROD_W'($past(in_period)));

  // R4
  sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_duty > UNITY) |=> s1_ctl.flag);
endmodule

// File: rtl/mapper_fine_stage.sv
module mapper_fine_stage
  import mapper_pkg::*;
#(
  parameter int DUTY_FRAC = 15,
  parameter int PER_W     = 16,
  parameter int SCL_W     = 8,
  localparam int PROD_W   = DUTY_FRAC + 1 + PER_W,
  localparam int RAW_W    = SCL_W + 1,
  localparam int MUL_W    = DUTY_FRAC + RAW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stage_ctl_t        s1_ctl,
  input  logic [PROD_W-1:0] s1_prod,
  input  logic [SCL_W-1:0]  s1_scale,
  output stage_ctl_t        s2_ctl,
  output logic [PER_W-1:0]  s2_coarse,
  output logic [RAW_W-1:0]  s2_raw
);
  localparam logic [MUL_W-1:0] HALF_STEP = MUL_W'(1) << (DUTY_FRAC - 1);

  logic [DUTY_FRAC-1:0] frac;
  logic [PER_W-1:0]     coarse_d;
  logic [MUL_W-1:0]     fine_sum;
  logic [RAW_W-1:0]     raw_d;

  always_comb begin
    frac     = s1_prod[DUTY_FRAC-1:0];
    coarse_d = s1_prod[DUTY_FRAC +: PER_W];
    fine_sum = MUL_W'(frac) * MUL_W'(s1_scale) + HALF_STEP;
    raw_d    = fine_sum[DUTY_FRAC +: RAW_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_ctl    <= '0;
      s2_coarse <= '0;
      s2_raw    <= '0;
    end else begin
      s2_ctl.vld <= s1_ctl.vld;
      if (s1_ctl.vld) begin
        s2_ctl.flag <= s1_ctl.flag;
        s2_coarse   <= coarse_d;
        s2_raw      <= raw_d;
      end
    end
  end

  // R1: duty is at most 1.0, so the product never reaches above the coarse field
  coarse_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_ctl.vld |-> s1_prod[PROD_W-1:DUTY_FRAC+PER_W] == '0);

  // R2: a remainder below one coarse step never rounds past the scale itself
  raw_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_ctl.vld |=> s2_raw <= RAW_W'($past(s1_scale)));
endmodule

// File: rtl/mapper_pack_stage.sv
module mapper_pack_stage
  import mapper_pkg::*;
#(
  parameter int PER_W   = 16,
  parameter int SCL_W   = 8,
  parameter int FINE_W  = 8,
  parameter int WORD_W  = 16,
  localparam int RAW_W  = SCL_W + 1,
  localparam int FINE_MAX = (1 << FINE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stage_ctl_t        s2_ctl,
  input  logic [PER_W-1:0]  s2_coarse,
  input  logic [RAW_W-1:0]  s2_raw,
  output logic              out_valid,
  output logic [PER_W-1:0]  out_coarse,
  output logic [WORD_W-1:0] out_fine,
  output logic              out_clamp
);
  logic [FINE_W-1:0] code_d;
  logic              lim_d;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    if (s2_raw == '0) begin
      code_d = FINE_W'(1);
      lim_d  = 1'b1;
    end else if (int'(s2_raw) > FINE_MAX) begin
      code_d = FINE_W'(FINE_MAX);
      lim_d  = 1'b1;
    end else begin
      code_d = FINE_W'(s2_raw);
      lim_d  = 1'b0;
    end
    word_d = {code_d, {(WORD_W-FINE_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_coarse <= '0;
      out_fine   <= '0;
      out_clamp  <= 1'b0;
    end else begin
      out_valid <= s2_ctl.vld;
      if (s2_ctl.vld) begin
        out_coarse <= s2_coarse;
        out_fine   <= word_d;
        out_clamp  <= lim_d | s2_ctl.flag;
      end
    end
  end

  // R3
  fine_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_fine[WORD_W-1 -: FINE_W] != '0);

  // R3
  zero_raw_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_ctl.vld && s2_raw == '0) |=> out_clamp);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_ctl.vld |=> ($stable(out_coarse) && $stable(out_fine) && $stable(out_clamp)));
endmodule

// File: rtl/duty_edge_mapper.sv
module duty_edge_mapper
  import mapper_pkg::*;
#(
  parameter int DUTY_FRAC = 15,
  parameter int PER_W     = 16,
  parameter int SCL_W     = 8,
  parameter int FINE_W    = 8,
  parameter int WORD_W    = 16,
  localparam int DUTY_W   = DUTY_FRAC + 1,
  localparam int PROD_W   = DUTY_W + PER_W,
  localparam int RAW_W    = SCL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DUTY_W-1:0] in_duty,
  input  logic [PER_W-1:0]  in_period,
  input  logic [SCL_W-1:0]  in_scale,
  output logic              out_valid,
  output logic [PER_W-1:0]  out_coarse,
  output logic [WORD_W-1:0] out_fine,
  output logic              out_clamp
);
  localparam logic [DUTY_W-1:0] UNITY = DUTY_W'(1) << DUTY_FRAC;

  stage_ctl_t        s1_ctl, s2_ctl;
  logic [PROD_W-1:0] s1_prod;
  logic [SCL_W-1:0]  s1_scale;
  logic [PER_W-1:0]  s2_coarse;
  logic [RAW_W-1:0]  s2_raw;

  assign in_ready = 1'b1;

  mapper_scale_stage #(.DUTY_FRAC(DUTY_FRAC), .PER_W(PER_W), .SCL_W(SCL_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_duty(in_duty),
    .in_period(in_period), .in_scale(in_scale),
    .s1_ctl(s1_ctl), .s1_prod(s1_prod), .s1_scale(s1_scale));

  mapper_fine_stage #(.DUTY_FRAC(DUTY_FRAC), .PER_W(PER_W), .SCL_W(SCL_W)) u_fine (
    .clk(clk), .rst_n(rst_n), .s1_ctl(s1_ctl), .s1_prod(s1_prod), .s1_scale(s1_scale),
    .s2_ctl(s2_ctl), .s2_coarse(s2_coarse), .s2_raw(s2_raw));

  mapper_pack_stage #(.PER_W(PER_W), .SCL_W(SCL_W), .FINE_W(FINE_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .s2_ctl(s2_ctl), .s2_coarse(s2_coarse), .s2_raw(s2_raw),
    .out_valid(out_valid), .out_coarse(out_coarse), .out_fine(out_fine),
    .out_clamp(out_clamp));

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##2 out_valid);

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##2 !out_valid);

  // R4
  sat_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_duty > UNITY) |=> ##2
      (out_clamp && out_coarse == $past(in_period, 3)));
endmodule

// File: tb/duty_edge_mapper_test.sv
module duty_edge_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_duty;
  logic [15:0] in_period;
  logic [7:0]  in_scale;
  logic        out_valid;
  logic [15:0] out_coarse;
  logic [15:0] out_fine;
  logic        out_clamp;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  duty_edge_mapper uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_duty(in_duty), .in_period(in_period), .in_scale(in_scale),
    .out_valid(out_valid), .out_coarse(out_coarse), .out_fine(out_fine),
    .out_clamp(out_clamp));

  // {duty, period, scale, coarse, fine, clamp}
  localparam int NV = 12;
  localparam logic [64:0] VEC [NV] = '{
    {16'd9830,  16'd72,    8'd61,  16'd21,    8'd37,  1'b0},  // R1 R2 30% case
    {16'h4000,  16'd100,   8'd61,  16'd50,    8'd1,   1'b1},  // R3 zero remainder
    {16'h4000,  16'd101,   8'd61,  16'd50,    8'd31,  1'b0},  // R2 half remainder
    {16'h2000,  16'd10,    8'd255, 16'd2,     8'd128, 1'b0},  // R2 max scale
    {16'h7FFF,  16'd65535, 8'd255, 16'd65533, 8'd1,   1'b1},  // R3 tiny remainder
    {16'h8000,  16'd72,    8'd61,  16'd72,    8'd1,   1'b1},  // R4 exactly 1.0
    {16'hFFFF,  16'd72,    8'd61,  16'd72,    8'd1,   1'b1},  // R4 above 1.0
    {16'd0,     16'd500,   8'd61,  16'd0,     8'd1,   1'b1},  // R3 zero duty
    {16'd9830,  16'd72,    8'd60,  16'd21,    8'd36,  1'b0},  // R2 round down
    {16'h4000,  16'd1,     8'd3,   16'd0,     8'd2,   1'b0},  // R2 exact half rounds up
    {16'h4000,  16'd1,     8'd1,   16'd0,     8'd1,   1'b0},  // R2 raw 1 not clamped
    {16'h4000,  16'd3,     8'd0,   16'd1,     8'd1,   1'b1}   // R3 zero scale
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_vec(input int j);
    logic [15:0] ec, ef;
    logic        ek;
    ec = VEC[j][24:9];
    ef = {VEC[j][8:1], 8'h00};
    ek = VEC[j][0];
    check(out_valid == 1'b1, "R6 valid pulse", 32'(out_valid), 32'd1);
    check(out_coarse == ec, "R1 coarse", 32'(out_coarse), 32'(ec));
    check(out_fine == ef, "R2 R5 fine word", 32'(out_fine), 32'(ef));
    check(out_clamp == ek, "R3 R4 clamp flag", 32'(out_clamp), 32'(ek));
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 5000);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_duty = '0; in_period = '0; in_scale = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid == 0 && out_coarse == 0 && out_fine == 0 && out_clamp == 0,
          "R8 reset outputs", {out_coarse, out_fine[15:8], 7'd0, out_valid | out_clamp}, 32'd0);
    check(in_ready == 1'b1, "R6 ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // back-to-back table: vector j visible three negedges after it is driven
    for (int i = 0; i < NV + 3; i++) begin
      if (i >= 3) check_vec(i - 3);
      check(in_ready == 1'b1, "R6 ready", 32'(in_ready), 32'd1);
      if (i < NV) begin
        in_valid = 1'b1;
        in_duty = VEC[i][64:49]; in_period = VEC[i][48:33]; in_scale = VEC[i][32:25];
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    check(out_valid == 1'b0, "R6 single-cycle pulse", 32'(out_valid), 32'd0);

    // R7: changing inputs with in_valid low leave outputs as the last result
    for (int k = 0; k < 6; k++) begin
      in_duty = 16'h1234 + 16'(k); in_period = 16'd999; in_scale = 8'd200;
      @(negedge clk);
      check(out_valid == 0 && out_coarse == 16'd1 && out_fine == 16'h0100 && out_clamp == 1,
            "R7 ignored inputs hold outputs", {out_coarse, out_fine}, 32'h0001_0100);
    end

    // R6 lone command: pulse appears exactly on the third edge
    in_valid = 1'b1; in_duty = 16'd9830; in_period = 16'd72; in_scale = 8'd61;
    @(negedge clk);
    in_valid = 1'b0; in_duty = 16'hFFFF;
    check(out_valid == 0, "R6 no early pulse edge1", 32'(out_valid), 32'd0);
    @(negedge clk);
    check(out_valid == 0, "R6 no early pulse edge2", 32'(out_valid), 32'd0);
    @(negedge clk);
    check_vec(0);
    @(negedge clk);
    check(out_valid == 0, "R6 pulse ends", 32'(out_valid), 32'd0);
    check(out_coarse == 16'd21 && out_fine == 16'h2500, "R7 hold after pulse",
          {out_coarse, out_fine}, 32'h0015_2500);

    // R8 reset while commands are in flight
    in_valid = 1'b1; in_duty = 16'h8000; in_period = 16'd300; in_scale = 8'd61;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && out_coarse == 0 && out_fine == 0 && out_clamp == 0,
          "R8 reset clears outputs", {out_coarse, out_fine}, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid == 0 && out_coarse == 0, "R8 in-flight commands dropped",
            {15'd0, out_valid, out_coarse}, 32'd0);
    end

    finish_run();
  end
endmodule